// File: doc/BRIEF.md
# Bandwidth-Gap Transmit Regulator

The regulator sits between a transmit queue, whose frames software has already put in order, and two Ethernet MACs that serve two redundant networks. It looks at the descriptor at the head of the queue. The descriptor carries a link number and a frame length. The regulator releases the frame only when that virtual link's bandwidth allocation gap has elapsed. Each link has a gap of 2^k milliseconds, with k from 0 to 7. Each link also has a jitter window. The window is the configured number of microseconds, limited to the range 40 to 500. A microsecond tick paces every timer.

When a frame is released, the regulator stamps it with the link's one-byte sequence number. It then raises a start request towards MAC A, MAC B or both, as the link's channel setting selects. It waits until every requested MAC has accepted the start before it takes the next descriptor. A frame sent inside the jitter window keeps the link's nominal cadence. A frame sent after the window has closed restarts the link's gap timer from the moment of the send. The per-link "gap reached" and "jitter expired" flags are outputs, so that a scheduler can see them.

Top module: `bgr_tx_regulator`

## Requirements
- R1: During and after reset, and before any tick, no start request is raised, `desc_ready` is low, and all `gap_ready` and `jit_late` bits are 0. Every link's sequence counter and timer restart from 0.
- R2: The head descriptor is taken (`desc_valid && desc_ready`) only when its link's `gap_ready` bit is set and no earlier frame still awaits a MAC acceptance. A head that is not eligible blocks the queue: frames are never reordered.
- R3: A link's timer counts `us_tick` pulses. `gap_ready[i]` is 1 while the count is at least US_PER_MS·2^k, where k is the link's 3-bit field `cfg_gap_exp[3i+2:3i]`. `jit_late[i]` is 1 while the count is at least that gap plus the jitter window. The count stops there, so an idle link stays eligible indefinitely.
- R4: A frame taken while its link's `jit_late` is 1 restarts that link's count, counting the tick of the same cycle. The link next becomes eligible one full gap later.
- R5: A frame taken d ticks after the gap was reached, while `jit_late` is still 0, keeps the cadence. The count drops by one gap, so the link becomes eligible again gap−d ticks after the send.
- R6: The jitter window is the 9-bit field `cfg_jitter_us[9i+8:9i]`, raised to 40 when it is below 40 and limited to 500 when it is above 500.
- R7: The 2-bit field `cfg_chan[2i+1:2i]` selects the MACs. Bit 0 selects MAC A and bit 1 selects MAC B. The value 00 means both. `tx_link`, `tx_len` and `tx_seq` describe the frame whose start is being requested.
- R8: A start request stays high, with `tx_link`, `tx_len` and `tx_seq` unchanged, until the MAC's `*_ack` is seen high with it at a clock edge.
- R9: For a dual-channel frame, no further descriptor is taken until both MACs have accepted the start. The skew between the two copies therefore bounds the hold-off of the next frame.
- R10: Each link's sequence number is 0 for its first frame after reset. It rises by one per frame and follows 255 with 1.
- R11: Timers advance only on cycles with `us_tick` high. Cycles without a tick move no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| desc_valid | input | 1 | Head descriptor present |
| desc_link | input | LINK_W | Virtual link of the head frame |
| desc_len | input | LEN_W | Length of the head frame in bytes |
| desc_ready | output | 1 | Head descriptor is taken at this edge when valid |
| cfg_gap_exp | input | 3·NUM_LINKS | Gap exponent k per link |
| cfg_jitter_us | input | 9·NUM_LINKS | Jitter window per link in µs |
| cfg_chan | input | 2·NUM_LINKS | Channel selection per link |
| a_req | output | 1 | Start request to MAC A |
| a_ack | input | 1 | MAC A accepts the start |
| b_req | output | 1 | Start request to MAC B |
| b_ack | input | 1 | MAC B accepts the start |
| tx_link | output | LINK_W | Link of the requested frame |
| tx_len | output | LEN_W | Length of the requested frame |
| tx_seq | output | 8 | Sequence number stamped on the frame |
| gap_ready | output | NUM_LINKS | Gap reached, per link |
| jit_late | output | NUM_LINKS | Jitter window expired, per link |

## Verification
A wrong timer count appears as a launch interval that is off by a few ticks. The bench sees it on the next frame of that link, or earlier on the `gap_ready` and `jit_late` outputs, which it samples tick by tick around their expected rising edges. The bench aims tests at both sides of the jitter boundary, so a swapped restart or rebase decision changes the next interval by tens of ticks. A corrupted sequence counter or a wrong channel choice appears at the very next MAC acceptance, where a scoreboard compares link, length and sequence number. A request that is dropped, or a fetch taken too early while one MAC stalls, appears within the stall.

// File: rtl/bgr_pkg.sv
package bgr_pkg;

  localparam int unsigned JIT_W       = 9;
  localparam int unsigned JIT_FLOOR   = 40;
  localparam int unsigned JIT_CEIL    = 500;

  // Gap length in ticks: one millisecond of ticks scaled by 2^k.
  function automatic int unsigned gap_ticks(input int unsigned per_ms, input logic [2:0] k);
    return per_ms << k;
  endfunction

  // Jitter window in ticks, held inside the allowed band.
  function automatic int unsigned jit_window(input logic [JIT_W-1:0] cfg_us);
    int unsigned v;
    v = int'(cfg_us);
    if (v < JIT_FLOOR) v = JIT_FLOOR;
    if (v > JIT_CEIL)  v = JIT_CEIL;
    return v;
  endfunction

  // Sequence successor: zero is only used after reset.
  function automatic logic [7:0] seq_after(input logic [7:0] s);
    return (s == 8'hFF) ? 8'h01 : s + 8'h01;
  endfunction

endpackage

// File: rtl/bgr_link_timer.sv
module bgr_link_timer import bgr_pkg::*; #(
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned CNT_W     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic [2:0]       gap_exp,
  input  logic [JIT_W-1:0] jit_cfg,
  input  logic             launch,
  output logic             gap_reached,
  output logic             jit_expired
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gap_t;
  logic [CNT_W-1:0] lim_t;

  assign gap_t = CNT_W'(gap_ticks(US_PER_MS, gap_exp));
  assign lim_t = gap_t + CNT_W'(jit_window(jit_cfg));

  assign gap_reached = (cnt >= gap_t);
  assign jit_expired = (cnt >= lim_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (launch) begin
      // late: restart; on time: rebase to the nominal slot
      if (jit_expired) cnt <= CNT_W'(us_tick);
      else             cnt <= cnt - gap_t + CNT_W'(us_tick);
    end else if (us_tick && !jit_expired) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bgr_seq_table.sv
module bgr_seq_table import bgr_pkg::*; #(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned LINK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] bump,
  input  logic [LINK_W-1:0]    rd_link,
  output logic [7:0]           rd_seq
);

  logic [7:0] seq_q [NUM_LINKS];

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_seq
    always_ff @(posedge clk) begin
      if (!rst_n)       seq_q[i] <= 8'h00;
      else if (bump[i]) seq_q[i] <= seq_after(seq_q[i]);
    end
  end

  assign rd_seq = seq_q[rd_link];

endmodule

// File: rtl/bgr_dispatch.sv
module bgr_dispatch #(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned LINK_W    = 2,
  parameter int unsigned LEN_W     = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   desc_valid,
  input  logic [LINK_W-1:0]      desc_link,
  input  logic [LEN_W-1:0]       desc_len,
  output logic                   desc_ready,
  input  logic [NUM_LINKS-1:0]   gap_reached,
  input  logic [2*NUM_LINKS-1:0] cfg_chan,
  input  logic [7:0]             head_seq,
  output logic                   pop,
  output logic [NUM_LINKS-1:0]   launch_vec,
  output logic                   a_req,
  input  logic                   a_ack,
  output logic                   b_req,
  input  logic                   b_ack,
  output logic [LINK_W-1:0]      tx_link,
  output logic [LEN_W-1:0]       tx_len,
  output logic [7:0]             tx_seq
);

  logic       a_pend, b_pend;
  logic [1:0] chan_sel, chan_want;

  assign chan_sel   = cfg_chan[{desc_link, 1'b0} +: 2];
  assign chan_want  = (chan_sel == 2'b00) ? 2'b11 : chan_sel;
  assign desc_ready = !(a_pend || b_pend) && gap_reached[desc_link];
  assign pop        = desc_valid && desc_ready;
  assign launch_vec = pop ? (NUM_LINKS'(1) << desc_link) : '0;
  assign a_req      = a_pend;
  assign b_req      = b_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_pend  <= 1'b0;
      b_pend  <= 1'b0;
      tx_link <= '0;
      tx_len  <= '0;
      tx_seq  <= '0;
    end else if (pop) begin
      a_pend  <= chan_want[0];
      b_pend  <= chan_want[1];
      tx_link <= desc_link;
      tx_len  <= desc_len;
      tx_seq  <= head_seq;
    end else begin
      a_pend  <= a_pend && !a_ack;
      b_pend  <= b_pend && !b_ack;
    end
  end

endmodule

// File: rtl/bgr_tx_regulator.sv
module bgr_tx_regulator import bgr_pkg::*; #(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned LEN_W     = 11,
  parameter int unsigned US_PER_MS = 1000,
  localparam int unsigned LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int unsigned CNT_W    = $clog2(US_PER_MS * 128 + JIT_CEIL + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       us_tick,
  input  logic                       desc_valid,
  input  logic [LINK_W-1:0]          desc_link,
  input  logic [LEN_W-1:0]           desc_len,
  output logic                       desc_ready,
  input  logic [3*NUM_LINKS-1:0]     cfg_gap_exp,
  input  logic [JIT_W*NUM_LINKS-1:0] cfg_jitter_us,
  input  logic [2*NUM_LINKS-1:0]     cfg_chan,
  output logic                       a_req,
  input  logic                       a_ack,
  output logic                       b_req,
  input  logic                       b_ack,
  output logic [LINK_W-1:0]          tx_link,
  output logic [LEN_W-1:0]           tx_len,
  output logic [7:0]                 tx_seq,
  output logic [NUM_LINKS-1:0]       gap_ready,
  output logic [NUM_LINKS-1:0]       jit_late
);

  // Named internal events, observed by the bound checker.
  logic                 frame_launch;
  logic                 late_launch;
  logic [NUM_LINKS-1:0] launch_vec;
  logic [7:0]           head_seq;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    bgr_link_timer #(.US_PER_MS(US_PER_MS), .CNT_W(CNT_W)) i_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .us_tick     (us_tick),
      .gap_exp     (cfg_gap_exp[3*i +: 3]),
      .jit_cfg     (cfg_jitter_us[JIT_W*i +: JIT_W]),
      .launch      (launch_vec[i]),
      .gap_reached (gap_ready[i]),
      .jit_expired (jit_late[i])
    );
  end

  bgr_seq_table #(.NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .bump    (launch_vec),
    .rd_link (desc_link),
    .rd_seq  (head_seq)
  );

  bgr_dispatch #(.NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W), .LEN_W(LEN_W)) i_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_link   (desc_link),
    .desc_len    (desc_len),
    .desc_ready  (desc_ready),
    .gap_reached (gap_ready),
    .cfg_chan    (cfg_chan),
    .head_seq    (head_seq),
    .pop         (frame_launch),
    .launch_vec  (launch_vec),
    .a_req       (a_req),
    .a_ack       (a_ack),
    .b_req       (b_req),
    .b_ack       (b_ack),
    .tx_link     (tx_link),
    .tx_len      (tx_len),
    .tx_seq      (tx_seq)
  );

  assign late_launch = frame_launch && jit_late[desc_link];

endmodule

// File: rtl/bgr_tx_regulator_chk.sv
module bgr_tx_regulator_chk #(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned LINK_W    = 2,
  parameter int unsigned LEN_W     = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LINK_W-1:0]    desc_link,
  input logic                 desc_ready,
  input logic                 frame_launch,
  input logic                 late_launch,
  input logic                 a_req,
  input logic                 a_ack,
  input logic                 b_req,
  input logic [LINK_W-1:0]    tx_link,
  input logic [LEN_W-1:0]     tx_len,
  input logic [7:0]           tx_seq,
  input logic [NUM_LINKS-1:0] gap_ready,
  input logic [NUM_LINKS-1:0] jit_late
);

  assert_gap_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_launch |-> gap_ready[desc_link]);

  assert_flag_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jit_late & ~gap_ready) == '0);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    late_launch |=> !gap_ready[$past(desc_link)]);

  assert_window_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_launch |=> !jit_late[$past(desc_link)]);

  assert_some_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_launch |=> (a_req || b_req));

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_ack) |=> (a_req && $stable(tx_seq) && $stable(tx_link) && $stable(tx_len)));

  assert_no_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req || b_req) |-> !desc_ready);

endmodule

bind bgr_tx_regulator bgr_tx_regulator_chk #(
  .NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W), .LEN_W(LEN_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .desc_link    (desc_link),
  .desc_ready   (desc_ready),
  .frame_launch (frame_launch),
  .late_launch  (late_launch),
  .a_req        (a_req),
  .a_ack        (a_ack),
  .b_req        (b_req),
  .tx_link      (tx_link),
  .tx_len       (tx_len),
  .tx_seq       (tx_seq),
  .gap_ready    (gap_ready),
  .jit_late     (jit_late)
);

// File: tb/test_bgr_tx_regulator.sv
`timescale 1ns/10ps
module test_bgr_tx_regulator;

  localparam int NL  = 4;
  localparam int LW  = 2;
  localparam int LNW = 11;
  localparam int PMS = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic desc_valid = 1'b0;
  logic [LW-1:0] desc_link = '0;
  logic [LNW-1:0] desc_len = '0;
  logic desc_ready;
  logic [3*NL-1:0] cfg_gap_exp = {3'd7, 3'd2, 3'd0, 3'd0};
  logic [9*NL-1:0] cfg_jitter_us = {9'd511, 9'd10, 9'd60, 9'd60};
  logic [2*NL-1:0] cfg_chan = {2'b11, 2'b00, 2'b10, 2'b01};
  logic a_req, b_req;
  logic a_ack = 1'b1, b_ack = 1'b1;
  logic [LW-1:0] tx_link;
  logic [LNW-1:0] tx_len;
  logic [7:0] tx_seq;
  logic [NL-1:0] gap_ready, jit_late;

  bgr_tx_regulator #(.NUM_LINKS(NL), .LEN_W(LNW), .US_PER_MS(PMS)) i_bgr_tx_regulator (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .desc_valid(desc_valid), .desc_link(desc_link), .desc_len(desc_len), .desc_ready(desc_ready),
    .cfg_gap_exp(cfg_gap_exp), .cfg_jitter_us(cfg_jitter_us), .cfg_chan(cfg_chan),
    .a_req(a_req), .a_ack(a_ack), .b_req(b_req), .b_ack(b_ack),
    .tx_link(tx_link), .tx_len(tx_len), .tx_seq(tx_seq),
    .gap_ready(gap_ready), .jit_late(jit_late)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] seq_model [NL];
  logic [31:0] qa[$], qb[$];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic at_cyc(input int n);
    while (cyc < n) @(negedge clk);
    #0.4;
  endtask

  // Driver: present a frame no earlier than edge 'target', return its launch edge.
  task automatic push_at(input int lk, input int ln, input int target, output int t_pop);
    logic [1:0] ch;
    logic [31:0] item;
    while (cyc < target - 1) @(negedge clk);
    desc_valid = 1'b1;
    desc_link  = LW'(lk);
    desc_len   = LNW'(ln);
    forever begin
      #0.2;
      if (desc_ready) break;
      @(negedge clk);
    end
    t_pop = cyc + 1;
    item = {8'(lk), 16'(ln), seq_model[lk]};
    ch = cfg_chan[2*lk +: 2];
    if (ch == 2'b00) ch = 2'b11;
    if (ch[0]) qa.push_back(item);
    if (ch[1]) qb.push_back(item);
    seq_model[lk] = (seq_model[lk] == 8'hFF) ? 8'h01 : seq_model[lk] + 8'h01;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic push(input int lk, input int ln, output int t_pop);
    push_at(lk, ln, 0, t_pop);
  endtask

  // Monitor: compare every MAC acceptance with the scoreboard (R7, R8, R10).
  always begin
    logic [31:0] got, want;
    @(negedge clk);
    #0.4;
    got = {8'(tx_link), 16'(tx_len), tx_seq};
    if (a_req && a_ack) begin
      if (qa.size() == 0) chk(0, "R7 unexpected frame on A", longint'(got), 0);
      else begin want = qa.pop_front(); chk(got == want, "R10/R7 frame on A", longint'(got), longint'(want)); end
    end
    if (b_req && b_ack) begin
      if (qb.size() == 0) chk(0, "R7 unexpected frame on B", longint'(got), 0);
      else begin want = qb.pop_front(); chk(got == want, "R10/R7 frame on B", longint'(got), longint'(want)); end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3, t4, t5, t6, t7;
    for (int i = 0; i < NL; i++) seq_model[i] = 8'h00;
    repeat (3) @(negedge clk);
    #0.4;
    // R1: state while in reset
    chk(!a_req && !b_req, "R1 requests in reset", {a_req, b_req}, 0);
    chk(gap_ready == '0 && jit_late == '0, "R1 flags in reset", {gap_ready, jit_late}, 0);
    chk(!desc_ready, "R1 ready in reset", desc_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    at_cyc(cyc + 2);
    chk(gap_ready == '0, "R1 flags after reset", gap_ready, 0);

    // R3/R10: link 0, gap 100, A only, back-to-back frames across the sequence wrap
    push(0, 64, t0);
    chk(b_req == 1'b0 && a_req == 1'b1, "R7 link0 uses A only", {a_req, b_req}, 2);
    for (int i = 1; i <= 256; i++) begin
      push(0, 64 + (i % 900), t1);
      if (i == 1 || i == 100 || i == 256)
        chk(t1 - t0 == 100, "R3 cadence k=0", t1 - t0, 100);
      if (i == 255) chk(tx_seq == 8'd255, "R10 seq reaches 255", tx_seq, 255);
      if (i == 256) chk(tx_seq == 8'd1, "R10 seq wraps to 1", tx_seq, 1);
      t0 = t1;
    end

    // R4/R5: link 1, gap 100, window 60, B only
    push(1, 200, t1);
    chk(a_req == 1'b0 && b_req == 1'b1, "R7 link1 uses B only", {a_req, b_req}, 1);
    push_at(1, 201, t1 + 130, t2);
    chk(t2 == t1 + 130, "R5 late send inside window", t2 - t1, 130);
    push(1, 202, t3);
    chk(t3 - t2 == 70, "R5 cadence kept", t3 - t2, 70);
    at_cyc(t3 + 158);
    chk(jit_late[1] == 1'b0, "R3 window still open", jit_late[1], 0);
    at_cyc(t3 + 159);
    chk(jit_late[1] == 1'b1, "R3 window expired", jit_late[1], 1);
    push_at(1, 203, t3 + 160, t4);
    push(1, 204, t5);
    chk(t5 - t4 == 100, "R4 restart after expiry", t5 - t4, 100);
    push_at(1, 205, t5 + 159, t6);
    push(1, 206, t7);
    chk(t7 - t6 == 41, "R5 last tick inside window", t7 - t6, 41);

    // R6: link 2, gap 400, configured 10 raised to 40, both channels
    push(2, 300, t1);
    chk(a_req && b_req, "R7 code 00 uses both", {a_req, b_req}, 3);
    push_at(2, 301, t1 + 439, t2);
    push(2, 302, t3);
    chk(t3 - t2 == 361, "R6 floor: 39 late is on time", t3 - t2, 361);
    push_at(2, 303, t3 + 440, t4);
    push(2, 304, t5);
    chk(t5 - t4 == 400, "R6 floor: 40 late restarts", t5 - t4, 400);

    // R11: ticks withheld for 30 cycles delay the gap flag by 30
    push(1, 400, t1);
    us_tick = 1'b0;
    repeat (30) @(negedge clk);
    us_tick = 1'b1;
    at_cyc(t1 + 128);
    chk(gap_ready[1] == 1'b0, "R11 flag held without ticks", gap_ready[1], 0);
    at_cyc(t1 + 129);
    chk(gap_ready[1] == 1'b1, "R11 flag after shifted gap", gap_ready[1], 1);

    // R9: link 3 dual, MAC B stalls; an eligible link-0 head must wait
    b_ack = 1'b0;
    push(3, 500, t1);
    fork
      push(0, 77, t2);
      begin
        repeat (20) @(negedge clk);
        #0.4;
        chk(gap_ready[0] == 1'b1, "R9 blocked head is eligible", gap_ready[0], 1);
        chk(!desc_ready, "R9 no fetch while B pending", desc_ready, 0);
        chk(!a_req && b_req, "R9 A done, B still requested", {a_req, b_req}, 1);
        @(negedge clk);
        b_ack = 1'b1;
      end
    join
    chk(t2 > t1 + 20, "R9 next fetch after both accepted", t2 - t1, 21);

    // R3/R6: k=7 gap and the 500 ceiling on the window
    push(3, 501, t3);
    chk(t3 - t1 == 12800, "R3 cadence k=7", t3 - t1, 12800);
    at_cyc(t3 + 12798);
    chk(gap_ready[3] == 1'b0, "R3 k=7 gap not yet", gap_ready[3], 0);
    at_cyc(t3 + 12799);
    chk(gap_ready[3] == 1'b1, "R3 k=7 gap reached", gap_ready[3], 1);
    at_cyc(t3 + 13298);
    chk(jit_late[3] == 1'b0, "R6 ceiling window open", jit_late[3], 0);
    at_cyc(t3 + 13299);
    chk(jit_late[3] == 1'b1, "R6 ceiling window 500", jit_late[3], 1);

    at_cyc(cyc + 5);
    chk(qa.size() == 0, "R7 A frames outstanding", qa.size(), 0);
    chk(qb.size() == 0, "R7 B frames outstanding", qb.size(), 0);
    finish_run();
  end

endmodule